// File: doc/BRIEF.md
# Load/Store Buffer Unit with Effective-Address Stations

This block keeps memory operations that have been issued to an out-of-order core. The core issues one load or store per cycle into a small ring of buffer entries. Each entry receives a base operand and an immediate offset. The base operand arrives either as a value or as the tag of the station that will produce it, and a store also receives its data as a value or a producer tag. An entry watches two result buses for its missing operands: the core's external result bus and the unit's own load-result bus. It first turns its offset field into an effective address, and only in a later cycle does it compete for the single memory port. Loads read a small internal memory and broadcast the data with their own station tag. Stores write the memory once both their address and their data are known.

Each entry runs a four-state machine. ENT_FREE goes to ENT_ADDR on allocation. ENT_ADDR goes to ENT_MEM once the base is known, and in that same transition the offset field becomes the effective address. ENT_MEM goes back to ENT_FREE when a store is granted the port, or to ENT_INFLIGHT when a load is granted. ENT_INFLIGHT goes to ENT_FREE in the cycle its result is broadcast.

The memory port runs a two-state machine. PORT_IDLE grants the oldest ready entry. A store grant writes the memory in that same cycle and stays in PORT_IDLE. A load grant starts a read and moves to PORT_LOAD_RESP. PORT_LOAD_RESP drives the load result for one cycle and returns to PORT_IDLE.

Loads must not pass older stores whose address matches theirs or is not yet known. A load that is older than a store is never held back by that store.

Top module: `lsb_unit`

## Requirements
- R1: After reset all entries are free, `issue_ready` is 1, `ldres_valid` is 0 and every memory word reads as 0.
- R2: The effective address is (base + offset) modulo 2^ADDR_W. It is formed in the cycle after the base becomes known, and the memory access that uses it happens in a later cycle.
- R3: A producer tag of 0 means the operand value is given at issue. A nonzero tag is resolved by the first beat whose tag matches, taken from either the external result bus or the unit's own load-result bus.
- R4: A load whose base is known at issue, that the port can serve at once and that no older store blocks, drives `ldres_valid` in the third cycle after the cycle its issue is accepted. A load whose base arrives on a bus drives `ldres_valid` in the second cycle after that bus beat. `ldres_data` is the memory word at the load's effective address.
- R5: A store writes the memory only after both its address and its data are known. Any later load of that address returns the written value.
- R6: The memory port makes at most one access per cycle. When several entries are ready, the oldest in issue order is served first. If a store wins the port, a younger ready load is served one cycle later. An older load that reads an address before a younger store writes it returns the old value.
- R7: A load waits while an older store is pending whose address equals the load's address or is still unknown. An older pending store with a different, known address does not delay the load.
- R8: An entry is freed when its load result is broadcast or its store write happens. `issue_ready` is 0 while every entry is occupied, and it rises again once entries are freed.
- R9: Entries are allocated in ring order starting at index 0 after reset. A load result carries `ldres_tag` = TAG_BASE + entry index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request this cycle |
| issue_store | input | 1 | 1 for a store, 0 for a load |
| issue_base_tag | input | TAG_W | Producer tag of the base operand, 0 if the value is given |
| issue_base_val | input | ADDR_W | Low address bits of the base operand when its tag is 0 |
| issue_offset | input | ADDR_W | Immediate offset, loaded into the address field |
| issue_data_tag | input | TAG_W | Producer tag of the store data, 0 if the value is given |
| issue_data_val | input | DATA_W | Store data when its tag is 0 |
| issue_ready | output | 1 | The unit can accept an issue this cycle |
| cdb_valid | input | 1 | External result bus beat valid |
| cdb_tag | input | TAG_W | Tag of the external result |
| cdb_data | input | DATA_W | Value of the external result |
| ldres_valid | output | 1 | Load result broadcast valid |
| ldres_tag | output | TAG_W | Station tag of the broadcasting load |
| ldres_data | output | DATA_W | Loaded data |

## Verification
The assertions take some behaviour of the environment for granted. The core offers an issue only while `issue_ready` is high. Nonzero producer tags never collide with the unit's own station tags unless they name one of its loads. The external result bus never repeats a tag that an entry in the unit is still waiting on. The stimulus keeps to these rules: it waits for `issue_ready` before each issue, it uses external tags 9 to 15 while the unit owns tags 1 to 4, and it broadcasts each external tag once per use. It also leaves idle cycles between phases, so the latency checks start from a known empty state.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    typedef enum logic [1:0] {
        ENT_FREE     = 2'd0,
        ENT_ADDR     = 2'd1,
        ENT_MEM      = 2'd2,
        ENT_INFLIGHT = 2'd3
    } ent_state_e;

    typedef enum logic [0:0] {
        PORT_IDLE      = 1'b0,
        PORT_LOAD_RESP = 1'b1
    } port_state_e;

endpackage

// File: rtl/lsb_mem.sv
module lsb_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            if (we) begin
                words_q[addr] <= wdata;
            end
            if (re) begin
                rdata_q <= words_q[addr];
            end
        end
    end

    assign rdata = rdata_q;

    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re)); // R6

endmodule

// File: rtl/lsb_entry.sv
module lsb_entry
    import lsb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              alloc_store,
    input  logic [TAG_W-1:0]  alloc_base_tag,
    input  logic [ADDR_W-1:0] alloc_base_val,
    input  logic [ADDR_W-1:0] alloc_offset,
    input  logic [TAG_W-1:0]  alloc_data_tag,
    input  logic [DATA_W-1:0] alloc_data_val,
    input  logic              bus_a_valid,
    input  logic [TAG_W-1:0]  bus_a_tag,
    input  logic [DATA_W-1:0] bus_a_data,
    input  logic              bus_b_valid,
    input  logic [TAG_W-1:0]  bus_b_tag,
    input  logic [DATA_W-1:0] bus_b_data,
    input  logic              grant,
    input  logic              done,
    output logic              busy,
    output logic              is_store,
    output logic              addr_ok,
    output logic              data_ok,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    ent_state_e        state_q, state_d;
    logic              store_q;
    logic              brdy_q, drdy_q;
    logic [TAG_W-1:0]  btag_q, dtag_q;
    logic [ADDR_W-1:0] bval_q, a_q;
    logic [DATA_W-1:0] dval_q;

    logic              base_hit_a, base_hit_b, data_hit_a, data_hit_b, base_now;
    logic [ADDR_W-1:0] base_sel;

    always_comb begin
        base_hit_a = bus_a_valid && !brdy_q && (bus_a_tag == btag_q);
        base_hit_b = bus_b_valid && !brdy_q && (bus_b_tag == btag_q);
        data_hit_a = bus_a_valid && !drdy_q && (bus_a_tag == dtag_q);
        data_hit_b = bus_b_valid && !drdy_q && (bus_b_tag == dtag_q);
        base_now   = brdy_q || base_hit_a || base_hit_b;
        if (brdy_q) begin
            base_sel = bval_q;
        end else if (base_hit_a) begin
            base_sel = bus_a_data[ADDR_W-1:0];
        end else begin
            base_sel = bus_b_data[ADDR_W-1:0];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE:     if (alloc)    state_d = ENT_ADDR;
            ENT_ADDR:     if (base_now) state_d = ENT_MEM;
            ENT_MEM:      if (grant)    state_d = store_q ? ENT_FREE : ENT_INFLIGHT;
            ENT_INFLIGHT: if (done)     state_d = ENT_FREE;
            default:                    state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            brdy_q  <= 1'b0;
            drdy_q  <= 1'b0;
            btag_q  <= '0;
            dtag_q  <= '0;
            bval_q  <= '0;
            a_q     <= '0;
            dval_q  <= '0;
        end else if (alloc) begin
            store_q <= alloc_store;
            a_q     <= alloc_offset;
            btag_q  <= alloc_base_tag;
            dtag_q  <= alloc_data_tag;
            if (alloc_base_tag == '0) begin
                brdy_q <= 1'b1;
                bval_q <= alloc_base_val;
            end else if (bus_a_valid && bus_a_tag == alloc_base_tag) begin
                brdy_q <= 1'b1;
                bval_q <= bus_a_data[ADDR_W-1:0];
            end else if (bus_b_valid && bus_b_tag == alloc_base_tag) begin
                brdy_q <= 1'b1;
                bval_q <= bus_b_data[ADDR_W-1:0];
            end else begin
                brdy_q <= 1'b0;
            end
            if (!alloc_store || alloc_data_tag == '0) begin
                drdy_q <= 1'b1;
                dval_q <= alloc_data_val;
            end else if (bus_a_valid && bus_a_tag == alloc_data_tag) begin
                drdy_q <= 1'b1;
                dval_q <= bus_a_data;
            end else if (bus_b_valid && bus_b_tag == alloc_data_tag) begin
                drdy_q <= 1'b1;
                dval_q <= bus_b_data;
            end else begin
                drdy_q <= 1'b0;
            end
        end else begin
            if (state_q == ENT_ADDR && base_now) begin
                a_q    <= a_q + base_sel;
                brdy_q <= 1'b1;
            end
            if (state_q != ENT_FREE) begin
                if (data_hit_a) begin
                    drdy_q <= 1'b1;
                    dval_q <= bus_a_data;
                end else if (data_hit_b) begin
                    drdy_q <= 1'b1;
                    dval_q <= bus_b_data;
                end
            end
        end
    end

    assign busy     = (state_q != ENT_FREE);
    assign is_store = store_q;
    assign addr_ok  = (state_q == ENT_MEM);
    assign data_ok  = drdy_q;
    assign addr     = a_q;
    assign data     = dval_q;

    AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> state_q == ENT_FREE); // R8
    AST_GRANT_ONLY_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> state_q == ENT_MEM); // R6
    AST_DONE_ONLY_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state_q == ENT_INFLIGHT); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_MEM && $past(state_q == ENT_MEM)) |-> $stable(a_q)); // R2
    AST_STORE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && store_q) |-> drdy_q); // R5

endmodule

// File: rtl/lsb_pick.sv
module lsb_pick #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             enable,
    input  logic [IDX_W-1:0]                 head,
    input  logic [ENTRIES-1:0]               busy,
    input  logic [ENTRIES-1:0]               is_store,
    input  logic [ENTRIES-1:0]               addr_ok,
    input  logic [ENTRIES-1:0]               data_ok,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   addrs,
    output logic                             grant_valid,
    output logic [IDX_W-1:0]                 grant_idx,
    output logic [ENTRIES-1:0]               grant_vec
);
    logic [ENTRIES-1:0] ready;

    function automatic int age_of(input int idx, input int h);
        return (idx >= h) ? (idx - h) : (idx + ENTRIES - h);
    endfunction

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && busy[j] && is_store[j] &&
                    age_of(j, int'(head)) < age_of(i, int'(head)) &&
                    (!addr_ok[j] || addrs[j] == addrs[i])) begin
                    blocked = 1'b1;
                end
            end
            if (is_store[i]) begin
                ready[i] = addr_ok[i] && data_ok[i];
            end else begin
                ready[i] = addr_ok[i] && !blocked;
            end
        end
    end

    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        grant_vec   = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            int idx;
            idx = (int'(head) + k) % ENTRIES;
            if (enable && !grant_valid && ready[idx]) begin
                grant_valid    = 1'b1;
                grant_idx      = IDX_W'(idx);
                grant_vec[idx] = 1'b1;
            end
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec)); // R6
    AST_GRANT_STORE_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && is_store[grant_idx]) |-> (addr_ok[grant_idx] && data_ok[grant_idx])); // R5

endmodule

// File: rtl/lsb_unit.sv
module lsb_unit
    import lsb_pkg::*;
#(
    parameter int ENTRIES  = 4,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_store,
    input  logic [TAG_W-1:0]  issue_base_tag,
    input  logic [ADDR_W-1:0] issue_base_val,
    input  logic [ADDR_W-1:0] issue_offset,
    input  logic [TAG_W-1:0]  issue_data_tag,
    input  logic [DATA_W-1:0] issue_data_val,
    output logic              issue_ready,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              ldres_valid,
    output logic [TAG_W-1:0]  ldres_tag,
    output logic [DATA_W-1:0] ldres_data
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    port_state_e port_q, port_d;
    logic [IDX_W-1:0] head_q, tail_q, resp_idx_q;

    logic [ENTRIES-1:0]             ent_busy, ent_store, ent_addr_ok, ent_data_ok;
    logic [ENTRIES-1:0]             ent_alloc, ent_grant, ent_done;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [ENTRIES-1:0][DATA_W-1:0] ent_data;

    logic              grant_valid;
    logic [IDX_W-1:0]  grant_idx;
    logic              issue_fire;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
        return (int'(p) == ENTRIES - 1) ? '0 : p + 1'b1;
    endfunction

    assign issue_ready = !ent_busy[tail_q] && !((tail_q == head_q) && (|ent_busy));
    assign issue_fire  = issue_valid && issue_ready;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
            assign ent_alloc[g] = issue_fire && (int'(tail_q) == g);
            assign ent_done[g]  = (port_q == PORT_LOAD_RESP) && (int'(resp_idx_q) == g);

            lsb_entry #(
                .ADDR_W (ADDR_W),
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W)
            ) u_entry (
                .clk            (clk),
                .rst_n          (rst_n),
                .alloc          (ent_alloc[g]),
                .alloc_store    (issue_store),
                .alloc_base_tag (issue_base_tag),
                .alloc_base_val (issue_base_val),
                .alloc_offset   (issue_offset),
                .alloc_data_tag (issue_data_tag),
                .alloc_data_val (issue_data_val),
                .bus_a_valid    (cdb_valid),
                .bus_a_tag      (cdb_tag),
                .bus_a_data     (cdb_data),
                .bus_b_valid    (ldres_valid),
                .bus_b_tag      (ldres_tag),
                .bus_b_data     (ldres_data),
                .grant          (ent_grant[g]),
                .done           (ent_done[g]),
                .busy           (ent_busy[g]),
                .is_store       (ent_store[g]),
                .addr_ok        (ent_addr_ok[g]),
                .data_ok        (ent_data_ok[g]),
                .addr           (ent_addr[g]),
                .data           (ent_data[g])
            );
        end
    endgenerate

    lsb_pick #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W)
    ) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (port_q == PORT_IDLE),
        .head        (head_q),
        .busy        (ent_busy),
        .is_store    (ent_store),
        .addr_ok     (ent_addr_ok),
        .data_ok     (ent_data_ok),
        .addrs       (ent_addr),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_vec   (ent_grant)
    );

    lsb_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        port_d = port_q;
        unique case (port_q)
            PORT_IDLE:      if (grant_valid && !ent_store[grant_idx]) port_d = PORT_LOAD_RESP;
            PORT_LOAD_RESP: port_d = PORT_IDLE;
            default:        port_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q     <= PORT_IDLE;
            resp_idx_q <= '0;
        end else begin
            port_q <= port_d;
            if (port_q == PORT_IDLE && grant_valid && !ent_store[grant_idx]) begin
                resp_idx_q <= grant_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (issue_fire) begin
                tail_q <= ring_next(tail_q);
            end
            if (!ent_busy[head_q] && ((head_q != tail_q) || (|ent_busy))) begin
                head_q <= ring_next(head_q);
            end
        end
    end

    always_comb begin
        mem_we      = grant_valid && ent_store[grant_idx];
        mem_re      = grant_valid && !ent_store[grant_idx];
        mem_addr    = ent_addr[grant_idx];
        mem_wdata   = ent_data[grant_idx];
        ldres_valid = (port_q == PORT_LOAD_RESP);
        ldres_tag   = TAG_W'(TAG_BASE) + TAG_W'(resp_idx_q);
        ldres_data  = mem_rdata;
    end

    AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q == PORT_LOAD_RESP) |-> $past(mem_re)); // R4
    AST_BCAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        ldres_valid |=> !ent_busy[resp_idx_q]); // R8
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (&ent_busy) |-> !issue_ready); // R8
    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ldres_valid |=> !ldres_valid); // R6

endmodule

// File: tb/tb_lsb_unit.sv
`timescale 1ns/1ps
module tb_lsb_unit;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int TW = 4;
    localparam int TB = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          issue_valid = 0, issue_store = 0;
    logic [TW-1:0] issue_base_tag = 0, issue_data_tag = 0;
    logic [AW-1:0] issue_base_val = 0, issue_offset = 0;
    logic [DW-1:0] issue_data_val = 0;
    logic          issue_ready;
    logic          cdb_valid = 0;
    logic [TW-1:0] cdb_tag = 0;
    logic [DW-1:0] cdb_data = 0;
    logic          ldres_valid;
    logic [TW-1:0] ldres_tag;
    logic [DW-1:0] ldres_data;

    lsb_unit #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .TAG_BASE(TB)) dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_store(issue_store),
        .issue_base_tag(issue_base_tag), .issue_base_val(issue_base_val),
        .issue_offset(issue_offset), .issue_data_tag(issue_data_tag),
        .issue_data_val(issue_data_val), .issue_ready(issue_ready),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .ldres_valid(ldres_valid), .ldres_tag(ldres_tag), .ldres_data(ldres_data)
    );

    int checks = 0;
    int errors = 0;
    int alloc_cnt = 0;
    logic [DW-1:0] model [16];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input bit st, input logic [TW-1:0] bt, input logic [AW-1:0] bv,
                         input logic [AW-1:0] off, input logic [TW-1:0] dt,
                         input logic [DW-1:0] dv, output logic [TW-1:0] tag);
        @(negedge clk);
        while (!issue_ready) @(negedge clk);
        issue_valid = 1; issue_store = st; issue_base_tag = bt; issue_base_val = bv;
        issue_offset = off; issue_data_tag = dt; issue_data_val = dv;
        tag = TW'(TB + (alloc_cnt % N));
        alloc_cnt++;
        @(posedge clk);
        #1 issue_valid = 0;
    endtask

    task automatic bcast(input logic [TW-1:0] tag, input logic [DW-1:0] val);
        @(negedge clk);
        cdb_valid = 1; cdb_tag = tag; cdb_data = val;
        @(posedge clk);
        #1 cdb_valid = 0;
    endtask

    task automatic wait_ld(input logic [TW-1:0] etag, input logic [DW-1:0] edata,
                           input string req, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (ldres_valid) break;
            n++;
            if (n > 40) break;
        end
        chk(ldres_valid, {req, " result broadcast"}, int'(ldres_valid), 1);
        if (ldres_valid) begin
            chk(ldres_tag == etag, "R9 result tag", int'(ldres_tag), int'(etag));
            chk(ldres_data == edata, {req, " load data"}, int'(ldres_data), int'(edata));
        end
    endtask

    task automatic quiet(input int cyc, input string req);
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            chk(!ldres_valid, {req, " load held"}, int'(ldres_valid), 0);
        end
    endtask

    task automatic load_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        logic [TW-1:0] t;
        int n;
        issue(0, 0, 0, a, 0, 0, t);
        wait_ld(t, exp, req, n);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [TW-1:0] t, t1, t2;
        int n;
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(issue_ready == 1, "R1 ready after reset", int'(issue_ready), 1);
        chk(ldres_valid == 0, "R1 no broadcast after reset", int'(ldres_valid), 0);

        // R1 cleared memory, R4 latency from issue, R9 first tag is TB+0
        issue(0, 0, 0, 5, 0, 0, t);
        wait_ld(t, 0, "R1", n);
        chk(n == 2, "R4 latency from issue", n, 2);

        // R2/R5 sweep: stores to every address with wrapped base+offset
        for (int a = 0; a < 16; a++) begin
            logic [AW-1:0] b;
            b = AW'(a * 5);
            model[a] = DW'(a * 37 + 11);
            issue(1, 0, b, AW'(a) - b, 0, model[a], t);
        end
        repeat (12) @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            logic [AW-1:0] b;
            b = AW'(15 - a * 3);
            issue(0, 0, b, AW'(a) - b, 0, 0, t);
            wait_ld(t, model[a], "R2", n);
            chk(n == 2, "R4 latency sweep", n, 2);
        end

        // R3 base resolved from the external bus
        issue(0, 9, 0, 2, 0, 0, t);
        quiet(5, "R3");
        bcast(9, 8'd4);
        wait_ld(t, model[6], "R3", n);
        chk(n == 1, "R4 latency after bus base", n, 1);

        // R3 store data resolved from the unit's own load broadcast
        repeat (4) @(negedge clk);
        issue(0, 0, 0, 0, 0, 0, t1);
        issue(1, 0, 0, 1, t1, 0, t2);
        wait_ld(t1, model[0], "R3", n);
        model[1] = model[0];
        repeat (4) @(negedge clk);
        load_chk(1, model[1], "R3 own-bus store data");

        // R7 older store to same address with data pending
        issue(1, 0, 0, 4, 10, 0, t1);
        issue(0, 0, 0, 4, 0, 0, t2);
        quiet(8, "R7 same address");
        bcast(10, 8'h5A);
        wait_ld(t2, 8'h5A, "R7", n);
        model[4] = 8'h5A;

        // R7 older store with unknown address
        issue(1, 11, 0, 0, 0, 8'h77, t1);
        issue(0, 0, 0, 3, 0, 0, t2);
        quiet(8, "R7 unknown address");
        bcast(11, 8'd9);
        wait_ld(t2, model[3], "R7", n);
        model[9] = 8'h77;
        repeat (4) @(negedge clk);
        load_chk(9, 8'h77, "R5 store after base resolved");

        // R7 older store to a different known address does not block
        issue(1, 0, 0, 2, 12, 0, t1);
        issue(0, 0, 0, 7, 0, 0, t2);
        wait_ld(t2, model[7], "R7", n);
        chk(n == 2, "R7 bypass latency", n, 2);
        bcast(12, 8'h33);
        model[2] = 8'h33;
        repeat (4) @(negedge clk);
        load_chk(2, 8'h33, "R5 store after data resolved");

        // R6 older store wins the port over a younger load ready together
        repeat (6) @(negedge clk);
        issue(1, 13, 0, 8, 0, 8'h44, t1);
        issue(0, 13, 0, 11, 0, 0, t2);
        bcast(13, 8'd0);
        wait_ld(t2, model[11], "R6", n);
        chk(n == 2, "R6 store first delays load", n, 2);
        model[8] = 8'h44;

        // R6 older load reads before younger store to the same address
        repeat (6) @(negedge clk);
        issue(0, 14, 0, 8, 0, 0, t1);
        issue(1, 14, 0, 8, 0, 8'h99, t2);
        bcast(14, 8'd0);
        wait_ld(t1, 8'h44, "R6 old value", n);
        chk(n == 1, "R6 load first latency", n, 1);
        model[8] = 8'h99;
        repeat (4) @(negedge clk);
        load_chk(8, 8'h99, "R5 younger store written");

        // R8 all entries occupied, then freed
        repeat (10) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            issue(1, 0, 0, AW'(12 + k), 15, 0, t);
        end
        @(negedge clk);
        chk(issue_ready == 0, "R8 full blocks issue", int'(issue_ready), 0);
        bcast(15, 8'hC3);
        repeat (10) @(negedge clk);
        chk(issue_ready == 1, "R8 ready after frees", int'(issue_ready), 1);
        for (int k = 0; k < 4; k++) begin
            model[12 + k] = 8'hC3;
            load_chk(AW'(12 + k), 8'hC3, "R8 stores drained");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule